// File: doc/BRIEF.md
# GPIO Edge-Capture Interrupt Combiner

This block watches a set of general-purpose pins, already synchronised to the local clock, and records edges. A rising edge is recorded only if rising capture is enabled for that pin. A falling edge is recorded only if falling capture is enabled. In both cases the pin must be configured as an input. Recorded edges sit in sticky status bits until software clears them. Software clears status by pulsing a clear strobe with a bank number and a mask, and every 1 in the mask clears the matching bit of that bank.

The pins are grouped in banks of equal width. The status is reduced to three registered, level-sensitive interrupt lines:
- a dedicated line for pin 0 of bank 0;
- a dedicated line for pin 1 of bank 0;
- one shared line for every other pin.

Separately, a one-cycle wake pulse is raised when the core is halted and any input pin listed in a fixed wake mask changes level. The wake pulse does not depend on the edge enables.

Edges are found by comparing each pin with a registered copy of its level from the previous cycle.

Top module: `gpio_edge_irq_combiner`

## Requirements
- R1: A pin configured as input (`pin_is_out` bit = 0) with its `rise_en` bit set, sampled at 1 after being sampled at 0 on the previous clock, sets its `edge_status` bit on that clock. If `rise_en` is clear, no capture occurs.
- R2: An input pin with its `fall_en` bit set, sampled at 0 after being sampled at 1, sets its `edge_status` bit on that clock.
- R3: A pin whose `pin_is_out` bit is 1 never sets its status bit and never causes a wake pulse, whatever its level does.
- R4: Status bits are sticky. They clear only when `clr_stb` is high and `clr_bank` equals the pin's bank number (pin index divided by the bank width), and only at the positions where `clr_mask` is 1. Other banks are not affected.
- R5: If an edge is captured on a bit in the same clock that clears that bit, the edge wins and the bit stays set.
- R6: `irq_pin0` equals status bit 0 and `irq_pin1` equals status bit 1, each delayed by one clock.
- R7: `irq_other` equals, one clock later, the OR of all status bits from index 2 up to the highest pin.
- R8: `wake_pulse` is high for the clock after any level change while `core_halted` is high. The change must be on an input pin whose bit is set in the wake mask. Per bank 0..3 the mask words are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F, bank 0 in the low word. Changes with `core_halted` low, or on unmasked pins, give no pulse.
- R9: After reset, status, the previous-level copy, all three interrupt lines and the wake pulse are 0. A pin that is high at the first clock after reset is therefore seen as a rising edge.
- R10: Status changes appear one clock after the edge is sampled, and the interrupt lines one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NUM_BANKS*BANK_W | Synchronised pin levels |
| pin_is_out | input | NUM_BANKS*BANK_W | 1 = pin is an output, excluded from capture and wake |
| rise_en | input | NUM_BANKS*BANK_W | Rising-edge capture enables |
| fall_en | input | NUM_BANKS*BANK_W | Falling-edge capture enables |
| core_halted | input | 1 | Core is halted; wake detection active |
| clr_stb | input | 1 | Write-one-to-clear strobe |
| clr_bank | input | IDX_W | Bank index the clear applies to |
| clr_mask | input | BANK_W | Bits to clear in the selected bank |
| edge_status | output | NUM_BANKS*BANK_W | Sticky captured-edge bits |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_other | output | 1 | Shared interrupt for all other pins |
| wake_pulse | output | 1 | One-cycle wake indication |

## Verification
The bench builds the block with its defaults: four banks of 32 pins and the fixed wake mask. These defaults bring within reach:
- the two bank-0 pins that have their own lines;
- a clear aimed at the wrong bank among four real banks;
- a shared line that collects pins from every bank;
- masked and unmasked wake pins in all four banks.

Directed cases cover the following, and a random phase then mixes directions, enables, levels and clears:
- edges on output pins;
- disabled edge directions;
- an edge colliding with its own clear;
- wake attempts while running.

// File: rtl/gpio_eic_pkg.sv
package gpio_eic_pkg;
  localparam int DEF_NUM_BANKS = 4;
  localparam int DEF_BANK_W    = 32;
  // bank 0 in the least significant word
  localparam logic [127:0] DEF_WAKE_MASK =
    128'h0012007F_EC080000_002001FC_8003FE1B;
endpackage

// File: rtl/eic_bank.sv
module eic_bank #(
  parameter int BANK_W   = 32,
  parameter int IDX_W    = 2,
  parameter int BANK_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] level,
  input  logic [BANK_W-1:0] is_out,
  input  logic [BANK_W-1:0] rise_en,
  input  logic [BANK_W-1:0] fall_en,
  input  logic              clr_stb,
  input  logic [IDX_W-1:0]  clr_bank,
  input  logic [BANK_W-1:0] clr_mask,
  output logic [BANK_W-1:0] status,
  output logic [BANK_W-1:0] in_change
);

  function automatic logic [BANK_W-1:0] rise_of(
    input logic [BANK_W-1:0] now, input logic [BANK_W-1:0] was,
    input logic [BANK_W-1:0] en,  input logic [BANK_W-1:0] outp);
    return now & ~was & en & ~outp;
  endfunction

  function automatic logic [BANK_W-1:0] fall_of(
    input logic [BANK_W-1:0] now, input logic [BANK_W-1:0] was,
    input logic [BANK_W-1:0] en,  input logic [BANK_W-1:0] outp);
    return ~now & was & en & ~outp;
  endfunction

  function automatic logic [BANK_W-1:0] toggles_of(
    input logic [BANK_W-1:0] now, input logic [BANK_W-1:0] was,
    input logic [BANK_W-1:0] outp);
    return (now ^ was) & ~outp;
  endfunction

  // a captured edge overrides a clear of the same bit
  function automatic logic [BANK_W-1:0] merge_status(
    input logic [BANK_W-1:0] old, input logic [BANK_W-1:0] clr,
    input logic [BANK_W-1:0] hit);
    return (old & ~clr) | hit;
  endfunction

  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] status_q;
  logic [BANK_W-1:0] rise_hit;
  logic [BANK_W-1:0] fall_hit;
  logic [BANK_W-1:0] edge_hit;
  logic [BANK_W-1:0] clr_vec;
  logic              clr_here;

  assign rise_hit  = rise_of(level, prev_q, rise_en, is_out);
  assign fall_hit  = fall_of(level, prev_q, fall_en, is_out);
  assign edge_hit  = rise_hit | fall_hit;
  assign clr_here  = clr_stb && (clr_bank == IDX_W'(BANK_IDX));
  assign clr_vec   = clr_here ? clr_mask : '0;
  assign in_change = toggles_of(level, prev_q, is_out);
  assign status    = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= level;
      status_q <= merge_status(status_q, clr_vec, edge_hit);
    end
  end

  // R1: enabled rising edge on an input is captured
  a_r1_rise_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_hit) |=> ((status_q & $past(rise_hit)) == $past(rise_hit)));

  // R2: enabled falling edge on an input is captured
  a_r2_fall_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall_hit) |=> ((status_q & $past(fall_hit)) == $past(fall_hit)));

  // R3: output pins never gain a status bit
  a_r3_out_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & $past(is_out)) == '0));

  // R4: without a clear to this bank no bit drops
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_here |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R4: bits drop only where the mask asked
  a_r4_clear_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_mask)) == '0));

  // R5: edge beats a clear on the same bit
  a_r5_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_here && |(edge_hit & clr_mask)) |=>
      ((status_q & $past(edge_hit & clr_mask)) == $past(edge_hit & clr_mask)));

endmodule

// File: rtl/eic_irq_merge.sv
module eic_irq_merge #(
  parameter int NPINS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] status,
  output logic             irq_pin0,
  output logic             irq_pin1,
  output logic             irq_other
);

  function automatic logic any_beyond_two(input logic [NPINS-1:0] v);
    return |v[NPINS-1:2];
  endfunction

  logic others_set;
  assign others_set = any_beyond_two(status);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pin0  <= 1'b0;
      irq_pin1  <= 1'b0;
      irq_other <= 1'b0;
    end else begin
      irq_pin0  <= status[0];
      irq_pin1  <= status[1];
      irq_other <= others_set;
    end
  end

  // R6: dedicated lines follow their status bits one clock later
  a_r6_pin0_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_pin0 == $past(status[0])));
  a_r6_pin1_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_pin1 == $past(status[1])));

  // R7: shared line rises only if some other bit was set
  a_r7_other_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_other) |-> ($past(status) & ~NPINS'(3)) != '0);

endmodule

// File: rtl/eic_wake.sv
module eic_wake #(
  parameter int               NPINS     = 128,
  parameter logic [NPINS-1:0] WAKE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] in_change,
  input  logic             core_halted,
  output logic             wake_pulse
);

  function automatic logic wake_cause(input logic [NPINS-1:0] chg,
                                      input logic halted);
    return halted && ((chg & WAKE_MASK) != '0);
  endfunction

  logic wake_hit;
  assign wake_hit = wake_cause(in_change, core_halted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_pulse <= 1'b0;
    else        wake_pulse <= wake_hit;
  end

  // R8: a pulse needs the core halted on the clock before
  a_r8_needs_halt: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(core_halted));

  // R8: a pulse needs a masked input change on the clock before
  a_r8_needs_masked_change: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> ($past(in_change) & WAKE_MASK) != '0);

endmodule

// File: rtl/gpio_edge_irq_combiner.sv
module gpio_edge_irq_combiner #(
  parameter int NUM_BANKS = gpio_eic_pkg::DEF_NUM_BANKS,
  parameter int BANK_W    = gpio_eic_pkg::DEF_BANK_W,
  parameter int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter logic [NUM_BANKS*BANK_W-1:0] WAKE_MASK =
    (NUM_BANKS*BANK_W)'(gpio_eic_pkg::DEF_WAKE_MASK)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_level,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_is_out,
  input  logic [NUM_BANKS*BANK_W-1:0] rise_en,
  input  logic [NUM_BANKS*BANK_W-1:0] fall_en,
  input  logic                        core_halted,
  input  logic                        clr_stb,
  input  logic [IDX_W-1:0]            clr_bank,
  input  logic [BANK_W-1:0]           clr_mask,
  output logic [NUM_BANKS*BANK_W-1:0] edge_status,
  output logic                        irq_pin0,
  output logic                        irq_pin1,
  output logic                        irq_other,
  output logic                        wake_pulse
);

  localparam int NPINS = NUM_BANKS * BANK_W;

  logic [NPINS-1:0] in_change;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    eic_bank #(
      .BANK_W  (BANK_W),
      .IDX_W   (IDX_W),
      .BANK_IDX(b)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (pin_level [b*BANK_W +: BANK_W]),
      .is_out   (pin_is_out[b*BANK_W +: BANK_W]),
      .rise_en  (rise_en   [b*BANK_W +: BANK_W]),
      .fall_en  (fall_en   [b*BANK_W +: BANK_W]),
      .clr_stb  (clr_stb),
      .clr_bank (clr_bank),
      .clr_mask (clr_mask),
      .status   (edge_status[b*BANK_W +: BANK_W]),
      .in_change(in_change  [b*BANK_W +: BANK_W])
    );
  end

  eic_irq_merge #(.NPINS(NPINS)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status   (edge_status),
    .irq_pin0 (irq_pin0),
    .irq_pin1 (irq_pin1),
    .irq_other(irq_other)
  );

  eic_wake #(.NPINS(NPINS), .WAKE_MASK(WAKE_MASK)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_change  (in_change),
    .core_halted(core_halted),
    .wake_pulse (wake_pulse)
  );

  // R9: reset leaves nothing pending
  a_r9_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_pin0 && !irq_pin1 && !irq_other && !wake_pulse));

endmodule

// File: tb/sim_gpio_edge_irq_combiner.sv
module sim_gpio_edge_irq_combiner;
  localparam int NP = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] lvl = '0, dir_out = '0, ren = '0, fen = '0;
  logic halted = 1'b0, clr_stb = 1'b0;
  logic [1:0] cbank = '0;
  logic [31:0] cmask = '0;
  logic [NP-1:0] st;
  logic i0, i1, ix, wk;

  always #4 clk = ~clk;  // 125 MHz

  gpio_edge_irq_combiner u0 (
    .clk(clk), .rst_n(rst_n), .pin_level(lvl), .pin_is_out(dir_out),
    .rise_en(ren), .fall_en(fen), .core_halted(halted), .clr_stb(clr_stb),
    .clr_bank(cbank), .clr_mask(cmask), .edge_status(st),
    .irq_pin0(i0), .irq_pin1(i1), .irq_other(ix), .wake_pulse(wk));

  int checks = 0, errors = 0;
  bit done = 0, started = 0;
  logic [31:0] wake_word [4];
  initial begin
    wake_word[0] = 32'h8003FE1B; wake_word[1] = 32'h002001FC;
    wake_word[2] = 32'hEC080000; wake_word[3] = 32'h0012007F;
  end

  // behavioural reference, one step per clock
  bit m_stat [NP];
  bit m_prev [NP];
  bit ns [NP];
  bit m_i0, m_i1, m_ix, m_wk;
  always @(posedge clk) begin
    bit other, wak, inp, up, dn, hit, cl;
    int b, k;
    started = 1;
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_stat[p] = 0; m_prev[p] = 0; end
      m_i0 = 0; m_i1 = 0; m_ix = 0; m_wk = 0;
    end else begin
      other = 0; wak = 0;
      for (int p = 2; p < NP; p++) other = other | m_stat[p];
      for (int p = 0; p < NP; p++) begin
        b = p / 32; k = p % 32;
        inp = !dir_out[p];
        up  = lvl[p] && !m_prev[p];
        dn  = !lvl[p] && m_prev[p];
        hit = inp && ((up && ren[p]) || (dn && fen[p]));
        cl  = clr_stb && (int'(cbank) == b) && cmask[k];
        ns[p] = hit ? 1'b1 : (cl ? 1'b0 : m_stat[p]);
        if (inp && (up || dn) && halted && wake_word[b][k]) wak = 1;
      end
      m_i0 = m_stat[0]; m_i1 = m_stat[1]; m_ix = other; m_wk = wak;
      for (int p = 0; p < NP; p++) begin m_stat[p] = ns[p]; m_prev[p] = lvl[p]; end
    end
  end

  function automatic logic [NP-1:0] model_vec();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = m_stat[p];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // R10: whole-output comparison against the model every clock
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R10 status vs model", st, model_vec());
      chk("R6 irq_pin0 vs model", NP'(i0), NP'(m_i0));
      chk("R6 irq_pin1 vs model", NP'(i1), NP'(m_i1));
      chk("R7 irq_other vs model", NP'(ix), NP'(m_ix));
      chk("R8 wake vs model", NP'(wk), NP'(m_wk));
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_clear(input int bank, input logic [31:0] m);
    clr_stb = 1; cbank = 2'(bank); cmask = m;
  endtask

  task automatic summary();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    summary();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R9 status after reset", st, '0);
    chk("R9 irqs and wake after reset", NP'({i0, i1, ix, wk}), '0);

    // rising capture on pin 0
    ren = '1;
    lvl[0] = 1; tick();
    chk("R1 pin0 captured", NP'(st[0]), 1);
    chk("R10 irq lags status", NP'(i0), 0);
    tick();
    chk("R6 irq_pin0 up", NP'(i0), 1);
    chk("R6 irq_pin1 quiet", NP'(i1), 0);
    chk("R7 irq_other quiet", NP'(ix), 0);

    do_clear(0, 32'h1); tick(); clr_stb = 0;
    chk("R4 clear pin0", NP'(st[0]), 0);
    tick();
    chk("R6 irq_pin0 down", NP'(i0), 0);

    // output pin vs input pin in bank 1
    dir_out[40] = 1; lvl[40] = 1; tick();
    chk("R3 output pin no capture", NP'(st[40]), 0);
    lvl[41] = 1; tick();
    chk("R1 pin41 captured", NP'(st[41]), 1);
    tick();
    chk("R7 irq_other up", NP'(ix), 1);
    do_clear(0, 32'hFFFF_FFFF); tick();
    chk("R4 other bank untouched", NP'(st[41]), 1);
    do_clear(1, 32'h200); tick(); clr_stb = 0;
    chk("R4 pin41 cleared", NP'(st[41]), 0);
    tick();
    chk("R7 irq_other down", NP'(ix), 0);

    // falling only on pin 70
    ren = '0; fen[70] = 1;
    lvl[70] = 1; tick();
    chk("R1 rise disabled no capture", NP'(st[70]), 0);
    lvl[70] = 0; tick();
    chk("R2 pin70 fall captured", NP'(st[70]), 1);
    do_clear(2, 32'h40); tick(); clr_stb = 0;
    chk("R4 pin70 cleared", NP'(st[70]), 0);

    // edge colliding with its own clear
    ren[1] = 1; fen[1] = 1;
    lvl[1] = 1; tick();
    chk("R1 pin1 captured", NP'(st[1]), 1);
    lvl[1] = 0; do_clear(0, 32'h2); tick(); clr_stb = 0;
    chk("R5 edge beats clear", NP'(st[1]), 1);
    tick();
    chk("R6 irq_pin1 up", NP'(i1), 1);
    do_clear(0, 32'h2); tick(); clr_stb = 0;
    chk("R4 pin1 cleared", NP'(st[1]), 0);

    // wake behaviour
    halted = 1;
    lvl[0] = 0; tick();
    chk("R8 wake on masked pin", NP'(wk), 1);
    tick();
    chk("R8 wake single pulse", NP'(wk), 0);
    lvl[2] = 1; tick();
    chk("R8 unmasked pin no wake", NP'(wk), 0);
    lvl[40] = 0; tick();
    chk("R3 output pin no wake", NP'(wk), 0);
    halted = 0; lvl[0] = 1; tick();
    chk("R8 running core no wake", NP'(wk), 0);

    // mixed random traffic, checked by the model every clock
    for (int n = 0; n < 600; n++) begin
      if (n % 100 == 0) begin
        dir_out = {$urandom, $urandom, $urandom, $urandom};
        ren = {$urandom, $urandom, $urandom, $urandom};
        fen = {$urandom, $urandom, $urandom, $urandom};
        halted = $urandom_range(0, 1) == 1;
      end
      lvl = lvl ^ ({$urandom, $urandom, $urandom, $urandom} &
                   {$urandom, $urandom, $urandom, $urandom});
      clr_stb = $urandom_range(0, 3) == 0;
      cbank = 2'($urandom_range(0, 3));
      cmask = $urandom;
      tick();
    end
    clr_stb = 0;
    tick();
    summary();
  end
endmodule